// File: doc/BRIEF.md
# Per-Lane Scratch Address Generator

This block turns one explicit private-memory (scratch) load or store into a byte address for every lane of a 64-lane wavefront. Each lane's offset is built from either one scalar offset shared by the whole wavefront or the lane's own vector offset, with the instruction's immediate offset added. That sum is then spread so that consecutive 4-byte columns are interleaved across all lanes, and a lane-times-element-size term keeps lanes from overlapping. The 64-bit scratch base is added last.

The instruction arrives on a valid/ready handshake, one at a time. The result is registered and held on the output until the consumer takes it. Only lanes enabled in the execution mask get a new address and a set valid bit. Disabled lanes keep whatever address they held before. An element size outside the supported set raises an error flag and enables no lane.

Top module: `scratch_addr_gen`

## Requirements
- R1: When the selector `scal_sel` equals 7'h7F, each lane's pre-swizzle offset is its own 32-bit vector offset plus `imm_off`, modulo 2^32.
- R2: For any other selector value, every lane's pre-swizzle offset is `scal_off` plus `imm_off`, modulo 2^32.
- R3: The swizzled offset of lane L is (off with its low 2 bits cleared) times 64, plus (off mod 4), plus L times `elem_bytes`, all modulo 2^32. Lane L occupies bits [64*L+63 : 64*L] of `lane_addr` and bits [32*L+31 : 32*L] of `vec_off`.
- R4: A lane address is `scratch_base` plus the zero-extended swizzled offset, as a full 64-bit add with carry into the upper word.
- R5: Bit L of `lane_valid` is set only when bit L of `exec_mask` was set at acceptance. An inactive lane's address keeps its previous value.
- R6: Only `elem_bytes` values 4, 8, 12 and 16 are legal. Any other value sets `size_err`, clears every `lane_valid` bit and leaves every lane address unchanged. A legal size clears `size_err`.
- R7: An instruction is accepted on a rising edge where `in_valid` and `in_ready` are both high. `out_valid` rises with the results on that same edge and stays high until an edge where `out_ready` is high with no new acceptance.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all outputs hold steady.
- R9: After reset, `out_valid`, `size_err` and all `lane_valid` bits are 0, every lane address is 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block can accept an instruction |
| scal_sel | input | 7 | Scalar-offset selector; 7'h7F selects vector offsets |
| scal_off | input | 32 | Shared scalar offset |
| vec_off | input | 2048 | Per-lane 32-bit vector offsets |
| imm_off | input | 32 | Instruction immediate offset |
| elem_bytes | input | 5 | Data operand size in bytes |
| scratch_base | input | 64 | Scratch region base address |
| exec_mask | input | 64 | Lane execution mask |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| lane_addr | output | 4096 | Per-lane 64-bit addresses |
| lane_valid | output | 64 | Lanes that received an address |
| size_err | output | 1 | Element size was illegal |

## Verification
A wrong selector decode or swizzle term shows up in the lane addresses on the cycle after acceptance, and usually in every active lane at once. A lane-index error shows only in the lanes above zero. A stale write enable shows up later: an inactive lane or an illegal-size instruction overwrites an address that the bench still expects to hold its old value. The bench sweeps element sizes, selectors, masks and offset wrap points, and it also checks that the disabled lanes keep their addresses. A handshake fault appears as `in_ready` or the held outputs changing while the consumer stalls.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int OFF_W = 32;
  typedef logic [OFF_W-1:0] off_t;

  // Spread an offset into STRIDE-byte columns interleaved over all lanes,
  // then add the per-lane element displacement. Wraps modulo 2^OFF_W.
  function automatic off_t swizzle_off(input off_t off, input off_t lane,
                                       input off_t es, input off_t stride,
                                       input off_t lanes);
    off_t col;
    off_t byt;
    col = off / stride;
    byt = off % stride;
    return col * (stride * lanes) + byt + lane * es;
  endfunction

  // Legal element size: non-zero, a whole number of columns, at most max_es.
  function automatic logic size_legal(input off_t es, input off_t stride,
                                      input off_t max_es);
    return (es != '0) && ((es % stride) == '0) && (es <= max_es);
  endfunction
endpackage

// File: rtl/scr_size_chk.sv
module scr_size_chk #(
  parameter int ES_W   = 5,
  parameter int STRIDE = 4,
  parameter int MAX_ES = 16
) (
  input  logic [ES_W-1:0] elem_bytes,
  output logic            size_ok
);
  import scr_pkg::*;
  always_comb begin
    size_ok = size_legal(off_t'(elem_bytes), off_t'(STRIDE), off_t'(MAX_ES));
  end
endmodule

// File: rtl/scr_lane_unit.sv
module scr_lane_unit #(
  parameter int LANE_IDX = 0,
  parameter int LANES    = 64,
  parameter int STRIDE   = 4,
  parameter int SEL_W    = 7,
  parameter int ES_W     = 5,
  parameter int ADDR_W   = 64,
  parameter logic [SEL_W-1:0] SENTINEL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  scr_pkg::off_t     soff,
  input  scr_pkg::off_t     voff,
  input  scr_pkg::off_t     imm,
  input  logic [ES_W-1:0]   es,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr_q
);
  import scr_pkg::*;

  localparam int PAD_W = ADDR_W - OFF_W;

  logic              use_vec;
  off_t              pre_off;
  off_t              spread_off;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    use_vec    = (sel == SENTINEL);
    pre_off    = (use_vec ? voff : soff) + imm;
    spread_off = swizzle_off(pre_off, off_t'(LANE_IDX), off_t'(es),
                             off_t'(STRIDE), off_t'(LANES));
    addr_d     = base + {{PAD_W{1'b0}}, spread_off};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (wr_en) addr_q <= addr_d;
  end

  // R5
  hold_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(addr_q));
endmodule

// File: rtl/scr_out_stage.sv
module scr_out_stage #(
  parameter int LANES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             size_ok,
  input  logic [LANES-1:0] mask,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [LANES-1:0] lane_valid,
  output logic             size_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      lane_valid <= '0;
      size_err   <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      lane_valid <= size_ok ? mask : '0;
      size_err   <= !size_ok;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R6
  err_no_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> (lane_valid == '0));

  // R7
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R5
  valid_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ((lane_valid & ~$past(mask)) == '0));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(lane_valid) && $stable(size_err)));
endmodule

// File: rtl/scratch_addr_gen.sv
module scratch_addr_gen #(
  parameter int LANES    = 64,
  parameter int STRIDE   = 4,
  parameter int SEL_W    = 7,
  parameter int ES_W     = 5,
  parameter int MAX_ES   = 16,
  parameter int ADDR_W   = 64,
  parameter logic [SEL_W-1:0] SENTINEL = 7'h7F
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [SEL_W-1:0]        scal_sel,
  input  logic [31:0]             scal_off,
  input  logic [LANES*32-1:0]     vec_off,
  input  logic [31:0]             imm_off,
  input  logic [ES_W-1:0]         elem_bytes,
  input  logic [ADDR_W-1:0]       scratch_base,
  input  logic [LANES-1:0]        exec_mask,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*ADDR_W-1:0] lane_addr,
  output logic [LANES-1:0]        lane_valid,
  output logic                    size_err
);
  import scr_pkg::*;

  // Named internal events for the assertions
  logic             accept;
  logic             size_ok;
  logic [LANES-1:0] lane_wr;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign lane_wr  = (accept && size_ok) ? exec_mask : '0;

  scr_size_chk #(.ES_W(ES_W), .STRIDE(STRIDE), .MAX_ES(MAX_ES)) u_size (
    .elem_bytes (elem_bytes),
    .size_ok    (size_ok)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    scr_lane_unit #(
      .LANE_IDX (g),
      .LANES    (LANES),
      .STRIDE   (STRIDE),
      .SEL_W    (SEL_W),
      .ES_W     (ES_W),
      .ADDR_W   (ADDR_W),
      .SENTINEL (SENTINEL)
    ) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (lane_wr[g]),
      .sel    (scal_sel),
      .soff   (scal_off),
      .voff   (vec_off[g*OFF_W +: OFF_W]),
      .imm    (imm_off),
      .es     (elem_bytes),
      .base   (scratch_base),
      .addr_q (lane_addr[g*ADDR_W +: ADDR_W])
    );
  end

  scr_out_stage #(.LANES(LANES)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .size_ok    (size_ok),
    .mask       (exec_mask),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .lane_valid (lane_valid),
    .size_err   (size_err)
  );

  // R8
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  stall_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(lane_addr));

  // R6
  bad_size_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !size_ok) |=> (size_err && $stable(lane_addr)));
endmodule

// File: tb/tb_scratch_addr_gen.sv
module tb_scratch_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 64;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [6:0] scal_sel = 0;
  logic [31:0] scal_off = 0;
  logic [NL*32-1:0] vec_off = '0;
  logic [31:0] imm_off = 0;
  logic [4:0] elem_bytes = 4;
  logic [63:0] scratch_base = 0;
  logic [NL-1:0] exec_mask = 0;
  logic out_valid;
  logic out_ready = 1;
  logic [NL*64-1:0] lane_addr;
  logic [NL-1:0] lane_valid;
  logic size_err;

  int n_tests = 0;
  int n_fail = 0;
  logic [63:0] exp_addr [NL];
  logic [NL-1:0] exp_lv = '0;
  logic exp_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scratch_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .scal_sel(scal_sel), .scal_off(scal_off), .vec_off(vec_off),
    .imm_off(imm_off), .elem_bytes(elem_bytes), .scratch_base(scratch_base),
    .exec_mask(exec_mask), .out_valid(out_valid), .out_ready(out_ready),
    .lane_addr(lane_addr), .lane_valid(lane_valid), .size_err(size_err)
  );

  // Reference: clear low bits, scale by 64 via shift, add remainder and lane term.
  function automatic logic [63:0] ref_addr(input logic [63:0] b, input logic [31:0] off,
                                           input int lane, input int es);
    logic [31:0] lo;
    logic [31:0] s;
    lo = off & 32'h3;
    s  = ((off - lo) << 6) + lo + 32'(lane * es);
    return b + {32'h0, s};
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic check_outputs(input string req);
    int bad;
    bad = -1;
    for (int l = 0; l < NL; l++)
      if (bad < 0 && lane_addr[l*64 +: 64] !== exp_addr[l]) bad = l;
    chk(bad < 0, req, "lane address",
        bad < 0 ? 64'h0 : lane_addr[bad*64 +: 64], bad < 0 ? 64'h0 : exp_addr[bad]);
    chk(lane_valid === exp_lv, req, "lane_valid", lane_valid, exp_lv);
    chk(size_err === exp_err, req, "size_err", 64'(size_err), 64'(exp_err));
  endtask

  task automatic set_inputs(input logic [6:0] sel, input logic [31:0] so,
                            input logic [31:0] im, input int es,
                            input logic [63:0] b, input logic [NL-1:0] m,
                            input logic [31:0] vseed);
    scal_sel = sel; scal_off = so; imm_off = im; elem_bytes = 5'(es);
    scratch_base = b; exec_mask = m;
    for (int l = 0; l < NL; l++)
      vec_off[l*32 +: 32] = vseed + 32'(l) * 32'h0100_0193 + 32'(l % 5);
  endtask

  // Model update for the instruction currently on the inputs.
  task automatic model_accept();
    logic legal;
    logic [31:0] pre;
    legal = (elem_bytes == 4) || (elem_bytes == 8) || (elem_bytes == 12) || (elem_bytes == 16);
    exp_err = !legal;
    exp_lv  = legal ? exec_mask : '0;
    if (legal)
      for (int l = 0; l < NL; l++)
        if (exec_mask[l]) begin
          pre = (scal_sel == 7'h7F) ? vec_off[l*32 +: 32] + imm_off : scal_off + imm_off;
          exp_addr[l] = ref_addr(scratch_base, pre, l, int'(elem_bytes));
        end
  endtask

  task automatic send(input logic [6:0] sel, input logic [31:0] so,
                      input logic [31:0] im, input int es,
                      input logic [63:0] b, input logic [NL-1:0] m,
                      input logic [31:0] vseed, input string req);
    @(negedge clk);
    set_inputs(sel, so, im, es, b, m, vseed);
    in_valid = 1;
    model_accept();
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk(out_valid === 1'b1, req, "out_valid after accept", 64'(out_valid), 64'h1);
    check_outputs(req);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int l = 0; l < NL; l++) exp_addr[l] = 64'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(out_valid === 1'b0, "R9", "out_valid", 64'(out_valid), 64'h0);
    chk(in_ready === 1'b1, "R9", "in_ready", 64'(in_ready), 64'h1);
    check_outputs("R9");
    rst_n = 1;

    // R2/R3: shared scalar offset, all legal sizes, several selectors
    for (int e = 4; e <= 16; e += 4)
      send(7'h00, 32'h0000_1235, 32'h0000_0010, e, 64'h0000_0001_0000_0000,
           '1, 32'h0, "R2");
    send(7'h7E, 32'h0000_0007, 32'h0, 8, 64'h1000, '1, 32'h0, "R3");
    send(7'h40, 32'h0001_0003, 32'h0000_0001, 12, 64'h0, '1, 32'h0, "R3");

    // R1: vector offsets per lane, sweep sizes and seeds
    for (int e = 4; e <= 16; e += 4)
      for (int s = 0; s < 3; s++)
        send(7'h7F, 32'hDEAD_BEEF, 32'(s * 13), e, 64'h0000_2000_0000_0000,
             '1, 32'(s) * 32'h1357_9BDF, "R1");

    // R3: modulo-2^32 wrap of pre-swizzle and spread terms
    send(7'h01, 32'hFFFF_FFFF, 32'h0000_0002, 16, 64'h0, '1, 32'h0, "R3");
    send(7'h7F, 32'h0, 32'h0400_0001, 4, 64'h0, '1, 32'hFC00_0000, "R3");

    // R4: carry from the low word into the high word of the base add
    send(7'h05, 32'hFFFF_FF00, 32'h0, 16, 64'h0000_0007_FFFF_FFF0, '1, 32'h0, "R4");
    send(7'h7F, 32'h0, 32'h3, 8, 64'hFFFF_FFFF_FFFF_FF00, '1, 32'h8000_0000, "R4");

    // R5: partial masks; inactive lanes keep earlier addresses
    send(7'h02, 32'h0000_0100, 32'h0, 4, 64'hAAAA_0000, 64'h5555_5555_5555_5555, 32'h0, "R5");
    send(7'h7F, 32'h0, 32'h4, 8, 64'hBBBB_0000, 64'hF0F0_0000_0000_0F0F, 32'h77, "R5");
    send(7'h03, 32'h9, 32'h0, 12, 64'hCCCC_0000, 64'h0, 32'h0, "R5");
    send(7'h03, 32'h9, 32'h0, 12, 64'hCCCC_0000, 64'h8000_0000_0000_0001, 32'h0, "R5");

    // R6: every illegal size in the field; no lane changes
    for (int e = 0; e < 32; e++)
      if (e != 4 && e != 8 && e != 12 && e != 16)
        send(7'h7F, 32'h1111, 32'h2222, e, 64'hEEEE_EEEE_0000_0000, '1,
             32'h1234, "R6");
    send(7'h00, 32'h40, 32'h0, 8, 64'h0, '1, 32'h0, "R6");

    // R7/R8: back-pressure
    @(negedge clk);
    out_ready = 0;
    set_inputs(7'h10, 32'h0000_0050, 32'h1, 4, 64'h5000, '1, 32'h0);
    in_valid = 1;
    model_accept();
    @(posedge clk);
    @(negedge clk);
    set_inputs(7'h7F, 32'h0, 32'h8, 16, 64'h6000, '1, 32'h99);
    chk(in_ready === 1'b0, "R8", "in_ready while stalled", 64'(in_ready), 64'h0);
    @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b1, "R7", "out_valid held", 64'(out_valid), 64'h1);
    check_outputs("R8");
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    model_accept();
    check_outputs("R7");
    @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R7", "out_valid drops after take", 64'(out_valid), 64'h0);
    chk(in_ready === 1'b1, "R7", "in_ready idle", 64'(in_ready), 64'h1);

    summary();
  end
endmodule